// File: doc/BRIEF.md
# Serial EEPROM Word and Identifier Reader

This block reads from a three-wire serial EEPROM by driving chip select, serial clock and a data line toward the memory, and by sampling the memory's data line. A single start pulse selects one of two operations. Word mode reads the 16-bit word at the 8-bit address given with the start. Identifier mode ignores that address and reads words 0x10, 0x11, 0x12 and 0x13 one after the other. Those four words are joined into a 64-bit unique identifier, with the first word read in the top 16 bits.

Each read is one chip-select frame. The frame opens with a select-plus-clock preamble, shifts out a read command and the address, and then captures 17 data periods. The first of those periods carries a dummy zero that is dropped. The frame closes with a trailing clock pulse while select is low. Every line change is held for a programmable number of system clocks and then waits for an external busy indication to clear. That wait is bounded, so a stuck busy line cannot hang the reader. When the operation completes, a one-cycle done pulse appears and the results stay on the outputs until the next operation completes.

Top module: `eeprom_id_reader`

## Requirements
- R1: After reset, chip select, serial clock, data out and done are low, and the word and identifier outputs are zero.
- R2: Every read frame begins with chip select and serial clock rising in the same cycle while data out is low.
- R3: After the preamble, the block shifts out a start bit of 1, then opcode bits 1 and 0, then the 8-bit address with the most significant bit first. Each bit is placed on data out while the serial clock is low and is held through the following rising edge.
- R4: The data phase has 17 serial clock periods, and data in is sampled at each rising edge. The first sample is a dummy and is discarded, and the remaining 16 samples form the word with the most significant bit first. Each frame therefore has 29 rising clock edges while chip select is high.
- R5: At the end of a frame, chip select falls while the serial clock is low. Exactly one serial clock pulse follows with chip select low, and then all three lines are low by the time done is raised.
- R6: In identifier mode, the address input is ignored and four frames read addresses 0x10 to 0x13 in that order. The identifier output becomes {word 0x10, word 0x11, word 0x12, word 0x13}, and the word output becomes word 0x13. In word mode, the identifier output is left unchanged.
- R7: While busy is low, each line state is held for HALF_CYC system clocks. Done therefore rises 61*HALF_CYC cycles after the clock edge that accepts a word-mode start, and 244*HALF_CYC cycles after one that accepts an identifier-mode start.
- R8: After HALF_CYC-1 cycles, a line state ends in the first cycle in which busy is low. If busy stays high, the state ends after POLL_LIMIT busy samples. With busy stuck high, a word read takes 61*(HALF_CYC-1+POLL_LIMIT) cycles and still returns correct data.
- R9: A start request that arrives while an operation is in progress is ignored. It produces no extra done pulse and does not alter the result.
- R10: Done is high for exactly one cycle per operation. The word and identifier outputs change only in the cycle in which done is high.
- R11: Data out changes only in cycles in which the serial clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| mode_i | input | 1 | 0 = single word read, 1 = identifier gather |
| addr_i | input | 8 | Word address for word mode |
| ee_busy_i | input | 1 | Busy indication that stretches each line state |
| ee_din_i | input | 1 | Serial data from the EEPROM |
| ee_cs_o | output | 1 | Chip select to the EEPROM |
| ee_sk_o | output | 1 | Serial clock to the EEPROM |
| ee_do_o | output | 1 | Serial data to the EEPROM |
| word_o | output | 16 | Last word read |
| id_o | output | 64 | Assembled 64-bit identifier |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the bounded busy wait. It only shows up when busy stays high for hundreds of cycles on every one of the 61 line states. The bench holds busy high for a whole word read and checks that the exact stretched latency appears and that the data is still correct. A separate run toggles busy pseudo-randomly, so that single line states end at different points within their wait windows. A second start is also injected in the middle of a frame to confirm that it is dropped. The bench checks the serial framing with an EEPROM responder built from edges seen at the ports, which also decodes the opcode and the address.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

    // Command preamble: start bit then the two read opcode bits, sent left first
    localparam int          CMD_W    = 3;
    localparam logic [2:0]  CMD_READ = 3'b110;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_state_e;

    // Index of the final line state of one read frame:
    // 1 preamble + 2 per header bit + 2 per data period + 4 closing states, minus 1
    function automatic int eerd_last_step(input int addr_w, input int data_w);
        return 2 * (CMD_W + addr_w) + 2 * (data_w + 1) + 4;
    endfunction

endpackage

// File: rtl/eerd_pace.sv
// Line-state timer: holds each state HALF_CYC cycles, then polls busy a bounded number of times
module eerd_pace #(
    parameter int HALF_CYC   = 4,
    parameter int POLL_LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic busy_i,
    output logic ready_o
);
    localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT + 1) : 1;
    localparam int CNT_W  = (HALF_CYC > 1) ? $clog2(HALF_CYC + 1) : 1;

    typedef struct packed {
        logic              active;
        logic [POLL_W-1:0] poll;
    } pace_t;

    pace_t pace_d, pace_q;
    logic  half_done;
    logic  poll_last;

    generate
        if (HALF_CYC <= 1) begin : g_no_half
            assign half_done = 1'b1;
        end else begin : g_half
            logic [CNT_W-1:0] cnt_d, cnt_q;
            always_comb begin
                cnt_d = cnt_q;
                if (kick_i) begin
                    cnt_d = '0;
                end else if (pace_q.active && !half_done) begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
            assign half_done = (cnt_q == CNT_W'(HALF_CYC - 1));
        end
    endgenerate

    assign poll_last = (pace_q.poll == POLL_W'(POLL_LIMIT - 1));
    assign ready_o   = pace_q.active && half_done && (!busy_i || poll_last);

    always_comb begin
        pace_d = pace_q;
        if (kick_i) begin
            pace_d.active = 1'b1;
            pace_d.poll   = '0;
        end else if (ready_o) begin
            pace_d.active = 1'b0;
        end else if (pace_q.active && half_done) begin
            pace_d.poll = pace_q.poll + POLL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pace_q <= '0;
        else        pace_q <= pace_d;
    end

endmodule

// File: rtl/eerd_lines.sv
// Decodes a frame step index into the three serial lines and a capture strobe
module eerd_lines
    import eerd_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int STEP_W = 6
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              cs_o,
    output logic              sk_o,
    output logic              do_o,
    output logic              cap_o
);
    localparam int OUT_BITS  = CMD_W + ADDR_W;
    localparam int HDR_LAST  = 2 * OUT_BITS;
    localparam int DAT_FIRST = HDR_LAST + 1;
    localparam int DAT_LAST  = HDR_LAST + 2 * (DATA_W + 1);
    localparam int TAIL_SEL  = DAT_LAST + 1;   // select drops, clock low
    localparam int TAIL_SK   = DAT_LAST + 2;   // lone clock pulse with select low

    logic [OUT_BITS-1:0] frame;
    assign frame = {CMD_READ, addr_i};

    always_comb begin
        int s;
        int k;
        s     = int'(step_i);
        k     = 0;
        cs_o  = 1'b0;
        sk_o  = 1'b0;
        do_o  = 1'b0;
        cap_o = 1'b0;
        if (s == 0) begin
            cs_o = 1'b1;
            sk_o = 1'b1;
        end else if (s <= HDR_LAST) begin
            k    = s - 1;
            cs_o = 1'b1;
            sk_o = (k % 2) == 1;
            do_o = frame[OUT_BITS - 1 - (k / 2)];
        end else if (s <= DAT_LAST) begin
            k     = s - DAT_FIRST;
            cs_o  = 1'b1;
            sk_o  = (k % 2) == 1;
            cap_o = (k % 2) == 1;
        end else if (s == TAIL_SK) begin
            sk_o = 1'b1;
        end else if (s == TAIL_SEL) begin
            sk_o = 1'b0;
        end
    end

endmodule

// File: rtl/eeprom_id_reader.sv
module eeprom_id_reader
    import eerd_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int ID_WORDS   = 4,
    parameter int ID_BASE    = 'h10,
    parameter int HALF_CYC   = 4,
    parameter int POLL_LIMIT = 200
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       mode_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic                       ee_busy_i,
    input  logic                       ee_din_i,
    output logic                       ee_cs_o,
    output logic                       ee_sk_o,
    output logic                       ee_do_o,
    output logic [DATA_W-1:0]          word_o,
    output logic [DATA_W*ID_WORDS-1:0] id_o,
    output logic                       done_o
);
    localparam int LAST   = eerd_last_step(ADDR_W, DATA_W);
    localparam int STEP_W = $clog2(LAST + 1);
    localparam int WIDX_W = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;
    localparam int ID_W   = DATA_W * ID_WORDS;
    localparam int ACC_W  = DATA_W * (ID_WORDS - 1);

    typedef struct packed {
        ctl_state_e        st;
        logic [STEP_W-1:0] step;
        logic [WIDX_W-1:0] widx;
        logic              mode;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] shreg;
        logic [ACC_W-1:0]  acc;
        logic [DATA_W-1:0] word;
        logic [ID_W-1:0]   id;
        logic              done;
        logic              cs;
        logic              sk;
        logic              dout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              accept, step_end, at_last, more_words, kick;
    logic [STEP_W-1:0] nxt_step;
    logic [ADDR_W-1:0] nxt_addr;
    logic              ln_cs, ln_sk, ln_do, ln_cap;
    logic              ready;
    logic [ID_W-1:0]   joined;

    // Which step comes next, and for which address
    always_comb begin
        accept     = (ctl_q.st == CTL_IDLE) && start_i;
        step_end   = (ctl_q.st == CTL_RUN) && ready;
        at_last    = (ctl_q.step == STEP_W'(LAST));
        more_words = ctl_q.mode && (ctl_q.widx != WIDX_W'(ID_WORDS - 1));
        kick       = accept || (step_end && (!at_last || more_words));
        if (accept || at_last) nxt_step = '0;
        else                   nxt_step = ctl_q.step + STEP_W'(1);
        if (accept)            nxt_addr = mode_i ? ADDR_W'(ID_BASE) : addr_i;
        else if (at_last)      nxt_addr = ctl_q.addr + ADDR_W'(1);
        else                   nxt_addr = ctl_q.addr;
    end

    eerd_lines #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .STEP_W (STEP_W)
    ) u_lines (
        .step_i (nxt_step),
        .addr_i (nxt_addr),
        .cs_o   (ln_cs),
        .sk_o   (ln_sk),
        .do_o   (ln_do),
        .cap_o  (ln_cap)
    );

    eerd_pace #(
        .HALF_CYC   (HALF_CYC),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .kick_i  (kick),
        .busy_i  (ee_busy_i),
        .ready_o (ready)
    );

    assign joined = {ctl_q.acc, ctl_q.shreg};

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (accept) begin
            ctl_d.st   = CTL_RUN;
            ctl_d.step = nxt_step;
            ctl_d.widx = '0;
            ctl_d.mode = mode_i;
            ctl_d.addr = nxt_addr;
            ctl_d.cs   = ln_cs;
            ctl_d.sk   = ln_sk;
            ctl_d.dout = ln_do;
        end else if (step_end) begin
            if (!at_last) begin
                ctl_d.step = nxt_step;
                ctl_d.cs   = ln_cs;
                ctl_d.sk   = ln_sk;
                ctl_d.dout = ln_do;
                if (ln_cap) begin
                    ctl_d.shreg = {ctl_q.shreg[DATA_W-2:0], ee_din_i};
                end
            end else if (more_words) begin
                ctl_d.acc  = joined[ACC_W-1:0];
                ctl_d.widx = ctl_q.widx + WIDX_W'(1);
                ctl_d.addr = nxt_addr;
                ctl_d.step = nxt_step;
                ctl_d.cs   = ln_cs;
                ctl_d.sk   = ln_sk;
                ctl_d.dout = ln_do;
            end else begin
                ctl_d.st   = CTL_IDLE;
                ctl_d.done = 1'b1;
                ctl_d.word = ctl_q.shreg;
                if (ctl_q.mode) ctl_d.id = joined;
                ctl_d.cs   = 1'b0;
                ctl_d.sk   = 1'b0;
                ctl_d.dout = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ee_cs_o = ctl_q.cs;
    assign ee_sk_o = ctl_q.sk;
    assign ee_do_o = ctl_q.dout;
    assign word_o  = ctl_q.word;
    assign id_o    = ctl_q.id;
    assign done_o  = ctl_q.done;

endmodule

// File: rtl/eeprom_id_reader_chk.sv
module eeprom_id_reader_chk #(
    parameter int DATA_W = 16,
    parameter int ID_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ee_cs_o,
    input logic              ee_sk_o,
    input logic              ee_do_o,
    input logic [DATA_W-1:0] word_o,
    input logic [ID_W-1:0]   id_o,
    input logic              done_o
);

    a_r2_preamble_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_cs_o) |-> (ee_sk_o && !ee_do_o));

    a_r5_select_drops_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs_o) |-> !ee_sk_o);

    a_r5_lines_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ee_cs_o && !ee_sk_o && !ee_do_o));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_word_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o != $past(word_o)) |-> done_o);

    a_r10_id_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        (id_o != $past(id_o)) |-> done_o);

    a_r11_data_moves_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_do_o != $past(ee_do_o)) |-> !ee_sk_o);

endmodule

bind eeprom_id_reader eeprom_id_reader_chk #(
    .DATA_W (DATA_W),
    .ID_W   (DATA_W * ID_WORDS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ee_cs_o (ee_cs_o),
    .ee_sk_o (ee_sk_o),
    .ee_do_o (ee_do_o),
    .word_o  (word_o),
    .id_o    (id_o),
    .done_o  (done_o)
);

// File: tb/eeprom_id_reader_test.sv
module eeprom_id_reader_test;
    localparam int HALF  = 2;
    localparam int POLL  = 200;
    localparam int STEPS = 61;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        busy = 1'b0;
    logic        din_r = 1'b0;
    logic        ee_cs, ee_sk, ee_do, done;
    logic [15:0] word;
    logic [63:0] id;

    always #4 clk = ~clk;

    eeprom_id_reader #(.HALF_CYC(HALF), .POLL_LIMIT(POLL)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .addr_i(addr),
        .ee_busy_i(busy), .ee_din_i(din_r), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk),
        .ee_do_o(ee_do), .word_o(word), .id_o(id), .done_o(done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t0     = 0;
    int done_seen = 0;
    int busy_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem(input logic [7:0] a);
        return {a[3:0] ^ 4'h9, a[7:4], a ^ 8'hC3};
    endfunction

    // ---------------- busy generator ----------------
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (busy_mode)
            1:       busy <= 1'b1;
            2:       busy <= lfsr[0] & lfsr[3];
            default: busy <= 1'b0;
        endcase
    end

    // ---------------- EEPROM responder (edge view from the ports) ----------------
    logic       psk = 1'b0, pcs = 1'b0, pdo = 1'b0;
    bit         got_start = 0;
    int         nhdr = 0, dn = 0;
    logic [9:0] hdr = '0;
    logic [7:0] exp_addr = '0;
    int         rises_cs = 0, rises_nocs = 0, do_bad = 0;

    always @(negedge clk) begin
        logic [15:0] w;
        if (rst_n) begin
            if (ee_cs && !pcs)   // R2
                check(ee_sk && !ee_do, "R2", "preamble sk/do", {ee_sk, ee_do}, 2'b10);
            if (ee_sk && psk && (ee_do != pdo)) do_bad++;   // R11
            if (ee_sk && !psk) begin
                if (ee_cs) begin
                    rises_cs++;
                    if (!got_start) begin
                        if (ee_do) got_start = 1;
                    end else if (nhdr < 10) begin
                        hdr = {hdr[8:0], ee_do};
                        nhdr++;
                    end else begin
                        dn++;
                    end
                end else begin
                    rises_nocs++;
                end
            end
            if (!ee_sk && psk && ee_cs && got_start && nhdr == 10) begin
                w = mem(hdr[7:0]);
                din_r = (dn == 0) ? 1'b0 : w[16 - dn];
            end
            if (!ee_cs && pcs) begin   // R3
                check(got_start && hdr[9:8] == 2'b10, "R3", "start+opcode", {got_start, hdr[9:8]}, 3'b110);
                check(hdr[7:0] == exp_addr, "R3", "address", hdr[7:0], exp_addr);
                check(dn == 17, "R4", "data periods", dn, 17);
                exp_addr = exp_addr + 8'd1;
                got_start = 0; nhdr = 0; dn = 0; din_r = 1'b0;
            end
        end
        psk = ee_sk; pcs = ee_cs; pdo = ee_do;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] w;
        logic [63:0] idv;
        int          lat;
        int          nr;
    } exp_t;

    exp_t        q[$];
    logic [63:0] last_id = '0;
    bit          prev_done = 0;

    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            if (prev_done)
                check(!done, "R10", "done width", done, 0);
            if (done) begin
                done_seen++;
                if (q.size() == 0) begin
                    check(0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(word == e.w, "R4", "word", word, e.w);
                    check(id == e.idv, "R6", "identifier", id, e.idv);
                    if (e.lat >= 0)
                        check(cyc - t0 == e.lat, "R7/R8 latency", "cycles", cyc - t0, e.lat);
                    check(rises_cs == 29 * e.nr, "R4", "select-high rises", rises_cs, 29 * e.nr);
                    check(rises_nocs == e.nr, "R5", "select-low pulses", rises_nocs, e.nr);
                    check(!ee_cs && !ee_sk && !ee_do, "R5", "lines at done",
                          {ee_cs, ee_sk, ee_do}, 0);
                    check(do_bad == 0, "R11", "do moved with sk high", do_bad, 0);
                end
            end
            prev_done = done;
        end
    end

    // ---------------- driver ----------------
    task automatic run_op(input bit m, input logic [7:0] a, input int lat, input bit poke);
        exp_t e;
        int   n0;
        e.w   = mem(m ? 8'h13 : a);
        e.idv = m ? {mem(8'h10), mem(8'h11), mem(8'h12), mem(8'h13)} : last_id;
        e.lat = lat;
        e.nr  = m ? 4 : 1;
        last_id = e.idv;
        q.push_back(e);
        n0 = done_seen;
        @(negedge clk);
        exp_addr = m ? 8'h10 : a;
        rises_cs = 0; rises_nocs = 0;
        mode = m; addr = a; start = 1'b1;
        @(posedge clk);
        #1 t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin   // R9: second request in the middle of the frame
            repeat (40) @(negedge clk);
            mode = ~m; addr = 8'h99; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_seen == n0) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        logic [15:0] hw;
        logic [63:0] hid;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({ee_cs, ee_sk, ee_do, done} == 4'b0, "R1", "lines after reset", {ee_cs, ee_sk, ee_do, done}, 0);
        check(word == 16'h0 && id == 64'h0, "R1", "results after reset", {word, id[47:0]}, 0);

        // R3 R4 R7: word reads, busy low
        run_op(0, 8'h00, STEPS * HALF, 0);
        run_op(0, 8'hA5, STEPS * HALF, 0);
        run_op(0, 8'hFF, STEPS * HALF, 0);
        run_op(0, 8'h3C, STEPS * HALF, 0);
        // R6: identifier, addr_i ignored
        run_op(1, 8'h77, 4 * STEPS * HALF, 0);
        // R8: busy stuck high
        busy_mode = 1;
        run_op(0, 8'h5E, STEPS * (HALF - 1 + POLL), 0);
        // R8: random busy
        busy_mode = 2;
        run_op(0, 8'h81, -1, 0);
        run_op(1, 8'h02, -1, 0);
        busy_mode = 0;
        // R9: start while running
        run_op(0, 8'h21, STEPS * HALF, 1);
        repeat (600) @(negedge clk);
        check(q.size() == 0, "R9", "queue drained", q.size(), 0);
        // R10: results hold while idle
        hw = word; hid = id;
        repeat (50) @(negedge clk);
        check(word == hw, "R10", "word held", word, hw);
        check(id == hid, "R10", "identifier held", id, hid);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule